// File: doc/BRIEF.md
# Kernel Stack Limit Checker

This block screens every data write made through a stack-pointer specifier while the processor runs in kernel mode. It decides whether the write lands too close to, or below, a programmable stack floor. The sequencer supplies six things: the write's effective address, a write strobe, the 3-bit addressing mode of the specifier, a flag saying that the specifier register is the stack pointer, the current processor mode, and the upper byte of the stack-limit register.

Two flags come back in the same cycle. The yellow flag marks a soft violation: the write is allowed to finish, and the sequencer raises a trap at the next instruction boundary. The red flag marks a hard violation: the sequencer must abort the write and enter its emergency stack flow. The block holds no state. Trap vectoring, emergency stack setup and address translation belong to the surrounding sequencer.

Only writes made through a specifier that changes or indexes the stack pointer with a write intent are screened. These are register-deferred, autoincrement, autodecrement and indexed, which are modes 1, 2, 4 and 6. The processor status word address at the top of the address space is always treated as a red address. This protects the status word if a push happens while the stack pointer is 0.

Top module: `kstack_guard`

## Requirements
- R1: When cpu_mode is not kernel (encoding 2'b00; supervisor is 2'b01, user is 2'b11), both flags are 0 whatever the other inputs are.
- R2: When spec_is_sp is 0, both flags are 0.
- R3: When wr_strobe is 0 (a read or no access), both flags are 0.
- R4: Only addressing modes 1, 2, 4 and 6 (spec_mode value) are screened. Modes 0, 3, 5 and 7 never raise a flag.
- R5: For a screened write, zone_red is 1 when wr_addr < stk_limit*256 + 0340 (octal), using unbounded (17-bit) arithmetic.
- R6: For a screened write, zone_yellow is 1 when stk_limit*256 + 0340 <= wr_addr <= stk_limit*256 + 0377 (octal).
- R7: For a screened write at wr_addr >= stk_limit*256 + 0400 (octal), both flags are 0, except for the address named in R8.
- R8: For a screened write to address 0177776 (octal, 16'hFFFE), zone_red is 1 for any stk_limit value.
- R9: At most one flag is 1 at a time. When an address falls in both the red and yellow rules, red wins.
- R10: The flags follow the inputs combinationally, with no clock cycle of latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_addr | input | 16 | Effective address of the data access |
| wr_strobe | input | 1 | 1 when the access is a write |
| spec_mode | input | 3 | Addressing mode of the specifier (0..7) |
| spec_is_sp | input | 1 | 1 when the specifier register is the stack pointer |
| cpu_mode | input | 2 | Current processor mode, 2'b00 = kernel |
| stk_limit | input | 8 | Upper address byte of the stack limit |
| zone_red | output | 1 | Hard violation: abort the write |
| zone_yellow | output | 1 | Soft violation: finish the write, then trap |

## Verification
Both flags are due in the same cycle as the inputs that produce them, because no register lies on any path. The bench therefore applies each stimulus on a falling clock edge and samples the flags one nanosecond later. That is well inside the same half period, and no rising edge falls between stimulus and sample. One directed step changes the address without waiting for any edge, to show that no cycle of latency is involved. The boundary addresses on either side of each zone edge are taken at a low limit, at a zero limit, and at the highest limit, where the legal edge lies past the top of the address space.

// File: rtl/kstack_guard_pkg.sv
// Package: shared constants and types for the kernel stack limit checker.
// Assumes a 2-bit processor mode field with kernel encoded as zero.
package kstack_guard_pkg;

    typedef enum logic [1:0] {
        CPU_KERNEL = 2'b00,
        CPU_SUPER  = 2'b01,
        CPU_RSVD   = 2'b10,
        CPU_USER   = 2'b11
    } cpu_mode_e;

    // Addressing modes whose write accesses are screened: 1, 2, 4, 6.
    localparam logic [7:0] SCREENED_MODES = 8'b0101_0110;

    // Offsets above the limit base (octal 0340 and 0400).
    localparam int RED_SPAN_DEF   = 224;
    localparam int LEGAL_SPAN_DEF = 256;

    // Status word address at the top of a 16-bit space (octal 177776).
    localparam logic [15:0] PSW_ADDR_DEF = 16'hFFFE;

endpackage

// File: rtl/kstack_guard_qual.sv
// Module: decides whether the current access is subject to the stack check.
// Assumes the mode mask has one bit per addressing mode, bit n set meaning
// mode n is screened. Purely combinational.
module kstack_guard_qual
    import kstack_guard_pkg::*;
#(
    parameter int         MODE_W     = 3,
    parameter int         CPU_MODE_W = 2,
    parameter logic [(1<<MODE_W)-1:0] MODE_MASK = SCREENED_MODES
) (
    input  logic                  wr_strobe,
    input  logic [MODE_W-1:0]     spec_mode,
    input  logic                  spec_is_sp,
    input  logic [CPU_MODE_W-1:0] cpu_mode,
    output logic                  screened
);
    localparam int N_MODES = 1 << MODE_W;

    logic [N_MODES-1:0] mode_hit;

    // One decoder slice per addressing mode, gated by the mask.
    for (genvar m = 0; m < N_MODES; m++) begin : g_mode
        assign mode_hit[m] = MODE_MASK[m] && (spec_mode == MODE_W'(m));
    end

    // Combine kernel, stack-pointer, write and mode conditions.
    always_comb begin
        screened = wr_strobe && spec_is_sp
                && (cpu_mode == CPU_MODE_W'(CPU_KERNEL))
                && (|mode_hit);
    end

endmodule

// File: rtl/kstack_guard_zone.sv
// Module: places an address relative to the stack limit. Reports whether
// it lies below the red/yellow edge, below the legal edge, or equals the
// status word address. Assumes the limit is the upper part of the address
// with a zero low part. Arithmetic is one bit wider, so the legal edge may
// lie past the top of the address space.
module kstack_guard_zone #(
    parameter int                ADDR_W     = 16,
    parameter int                LIM_W      = 8,
    parameter int                RED_SPAN   = 224,
    parameter int                LEGAL_SPAN = 256,
    parameter logic [ADDR_W-1:0] PSW_ADDR   = 16'hFFFE
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [LIM_W-1:0]  limit,
    output logic              below_red_edge,
    output logic              below_legal_edge,
    output logic              at_psw
);
    localparam int LOW_W = ADDR_W - LIM_W;
    localparam int EXT_W = ADDR_W + 1;

    logic [EXT_W-1:0] base_x;
    logic [EXT_W-1:0] red_edge_x;
    logic [EXT_W-1:0] legal_edge_x;
    logic [EXT_W-1:0] addr_x;

    // Build the zone edges from the limit byte.
    always_comb begin
        base_x       = {1'b0, limit, {LOW_W{1'b0}}};
        red_edge_x   = base_x + EXT_W'(RED_SPAN);
        legal_edge_x = base_x + EXT_W'(LEGAL_SPAN);
        addr_x       = {1'b0, addr};
    end

    // Compare the address against both edges and the status word.
    always_comb begin
        below_red_edge   = addr_x < red_edge_x;
        below_legal_edge = addr_x < legal_edge_x;
        at_psw           = addr == PSW_ADDR;
    end

endmodule

// File: rtl/kstack_guard_arb.sv
// Module: turns the qualification and zone results into exclusive red and
// yellow flags, red taking priority. PSW_GUARD selects whether the status
// word address is forced into the red zone.
module kstack_guard_arb #(
    parameter bit PSW_GUARD = 1'b1
) (
    input  logic screened,
    input  logic below_red_edge,
    input  logic below_legal_edge,
    input  logic at_psw,
    output logic red,
    output logic yellow
);
    logic red_hit;

    // Choose the red-zone rule with or without status word protection.
    if (PSW_GUARD) begin : g_psw
        assign red_hit = below_red_edge || at_psw;
    end else begin : g_nopsw
        assign red_hit = below_red_edge;
    end

    // Resolve priority: red first, yellow only when red is absent.
    always_comb begin
        red    = screened && red_hit;
        yellow = screened && !red_hit && below_legal_edge;
    end

endmodule

// File: rtl/kstack_guard.sv
// Module: kernel stack limit checker top. Flags writes through stack
// pointer specifiers in kernel mode that fall below the limit (red) or
// just above it (yellow). Assumes the limit input is the upper byte of the
// limit register. Fully combinational: the flags are valid in the same
// cycle as the inputs.
module kstack_guard
    import kstack_guard_pkg::*;
#(
    parameter int                ADDR_W     = 16,
    parameter int                LIM_W      = 8,
    parameter int                MODE_W     = 3,
    parameter int                CPU_MODE_W = 2,
    parameter int                RED_SPAN   = RED_SPAN_DEF,
    parameter int                LEGAL_SPAN = LEGAL_SPAN_DEF,
    parameter logic [ADDR_W-1:0] PSW_ADDR   = PSW_ADDR_DEF,
    parameter bit                PSW_GUARD  = 1'b1
) (
    input  logic [15:0] wr_addr,
    input  logic        wr_strobe,
    input  logic [2:0]  spec_mode,
    input  logic        spec_is_sp,
    input  logic [1:0]  cpu_mode,
    input  logic [7:0]  stk_limit,
    output logic        zone_red,
    output logic        zone_yellow
);
    logic screened;
    logic below_red_edge;
    logic below_legal_edge;
    logic at_psw;

    kstack_guard_qual #(
        .MODE_W     (MODE_W),
        .CPU_MODE_W (CPU_MODE_W),
        .MODE_MASK  (SCREENED_MODES)
    ) u_qual (
        .wr_strobe  (wr_strobe),
        .spec_mode  (spec_mode),
        .spec_is_sp (spec_is_sp),
        .cpu_mode   (cpu_mode),
        .screened   (screened)
    );

    kstack_guard_zone #(
        .ADDR_W     (ADDR_W),
        .LIM_W      (LIM_W),
        .RED_SPAN   (RED_SPAN),
        .LEGAL_SPAN (LEGAL_SPAN),
        .PSW_ADDR   (PSW_ADDR)
    ) u_zone (
        .addr             (wr_addr),
        .limit            (stk_limit),
        .below_red_edge   (below_red_edge),
        .below_legal_edge (below_legal_edge),
        .at_psw           (at_psw)
    );

    kstack_guard_arb #(
        .PSW_GUARD (PSW_GUARD)
    ) u_arb (
        .screened         (screened),
        .below_red_edge   (below_red_edge),
        .below_legal_edge (below_legal_edge),
        .at_psw           (at_psw),
        .red              (zone_red),
        .yellow           (zone_yellow)
    );

endmodule

// File: rtl/kstack_guard_chk.sv
// Checker: port-level rules of the kernel stack limit checker, attached
// by bind. The block has no clock, so the checks are immediate assertions
// evaluated whenever the ports change.
module kstack_guard_chk (
    input logic [15:0] wr_addr,
    input logic        wr_strobe,
    input logic [2:0]  spec_mode,
    input logic        spec_is_sp,
    input logic [1:0]  cpu_mode,
    input logic [7:0]  stk_limit,
    input logic        zone_red,
    input logic        zone_yellow
);
    logic quiet;
    logic screened_mode;

    // Port-level views used by the assertions.
    always_comb begin
        quiet         = !zone_red && !zone_yellow;
        screened_mode = (spec_mode == 3'd1) || (spec_mode == 3'd2)
                     || (spec_mode == 3'd4) || (spec_mode == 3'd6);
    end

    // Assertions on every input change.
    always_comb begin
        assert_non_kernel_quiet_R1: assert (cpu_mode == 2'b00 || quiet)
            else $error("flag raised outside kernel mode");
        assert_non_sp_quiet_R2: assert (spec_is_sp || quiet)
            else $error("flag raised for non-SP specifier");
        assert_read_quiet_R3: assert (wr_strobe || quiet)
            else $error("flag raised on a read");
        assert_mode_quiet_R4: assert (screened_mode || quiet)
            else $error("flag raised for unscreened mode");
        assert_psw_red_R8: assert (!(wr_strobe && spec_is_sp && cpu_mode == 2'b00
                                    && screened_mode && wr_addr == 16'hFFFE) || zone_red)
            else $error("status word write not red, limit %h", stk_limit);
        assert_exclusive_R9: assert (!(zone_red && zone_yellow))
            else $error("both flags raised");
    end

endmodule

bind kstack_guard kstack_guard_chk u_chk (
    .wr_addr     (wr_addr),
    .wr_strobe   (wr_strobe),
    .spec_mode   (spec_mode),
    .spec_is_sp  (spec_is_sp),
    .cpu_mode    (cpu_mode),
    .stk_limit   (stk_limit),
    .zone_red    (zone_red),
    .zone_yellow (zone_yellow)
);

// File: tb/tb_kstack_guard.sv
// Bench: walks a vector table, then runs directed corner cases.
module tb_kstack_guard;

    logic        clk = 1'b0;
    logic [15:0] wr_addr;
    logic        wr_strobe;
    logic [2:0]  spec_mode;
    logic        spec_is_sp;
    logic [1:0]  cpu_mode;
    logic [7:0]  stk_limit;
    logic        zone_red;
    logic        zone_yellow;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    kstack_guard dut (
        .wr_addr     (wr_addr),
        .wr_strobe   (wr_strobe),
        .spec_mode   (spec_mode),
        .spec_is_sp  (spec_is_sp),
        .cpu_mode    (cpu_mode),
        .stk_limit   (stk_limit),
        .zone_red    (zone_red),
        .zone_yellow (zone_yellow)
    );

    // Vector: {we, sp, cpu[2], amode[3], limit[8], addr[16], red, yel, req[4]}
    localparam int NV = 30;
    localparam logic [36:0] VEC [NV] = '{
        {1'b1, 1'b1, 2'b00, 3'd1, 8'h04, 16'h04DF, 1'b1, 1'b0, 4'd5},  // R5 just below edge
        {1'b1, 1'b1, 2'b00, 3'd1, 8'h04, 16'h0000, 1'b1, 1'b0, 4'd5},  // R5 far below
        {1'b1, 1'b1, 2'b00, 3'd2, 8'h04, 16'h0400, 1'b1, 1'b0, 4'd5},  // R5 at base
        {1'b1, 1'b1, 2'b00, 3'd1, 8'h04, 16'h04E0, 1'b0, 1'b1, 4'd6},  // R6 yellow low edge
        {1'b1, 1'b1, 2'b00, 3'd1, 8'h04, 16'h04FF, 1'b0, 1'b1, 4'd6},  // R6 yellow top
        {1'b1, 1'b1, 2'b00, 3'd1, 8'h04, 16'h0500, 1'b0, 1'b0, 4'd7},  // R7 first legal
        {1'b1, 1'b1, 2'b00, 3'd1, 8'h04, 16'h8000, 1'b0, 1'b0, 4'd7},  // R7 far above
        {1'b1, 1'b1, 2'b00, 3'd2, 8'h04, 16'h04F0, 1'b0, 1'b1, 4'd4},  // R4 mode 2
        {1'b1, 1'b1, 2'b00, 3'd4, 8'h04, 16'h04F0, 1'b0, 1'b1, 4'd4},  // R4 mode 4
        {1'b1, 1'b1, 2'b00, 3'd6, 8'h04, 16'h04F0, 1'b0, 1'b1, 4'd4},  // R4 mode 6
        {1'b1, 1'b1, 2'b00, 3'd0, 8'h04, 16'h0100, 1'b0, 1'b0, 4'd4},  // R4 mode 0
        {1'b1, 1'b1, 2'b00, 3'd3, 8'h04, 16'h0100, 1'b0, 1'b0, 4'd4},  // R4 mode 3
        {1'b1, 1'b1, 2'b00, 3'd5, 8'h04, 16'h0100, 1'b0, 1'b0, 4'd4},  // R4 mode 5
        {1'b1, 1'b1, 2'b00, 3'd7, 8'h04, 16'h0100, 1'b0, 1'b0, 4'd4},  // R4 mode 7
        {1'b1, 1'b1, 2'b01, 3'd1, 8'h04, 16'h0100, 1'b0, 1'b0, 4'd1},  // R1 supervisor
        {1'b1, 1'b1, 2'b11, 3'd4, 8'h04, 16'h04F0, 1'b0, 1'b0, 4'd1},  // R1 user
        {1'b1, 1'b1, 2'b11, 3'd4, 8'h04, 16'hFFFE, 1'b0, 1'b0, 4'd1},  // R1 user at PSW
        {1'b1, 1'b0, 2'b00, 3'd1, 8'h04, 16'h0100, 1'b0, 1'b0, 4'd2},  // R2 not SP
        {1'b1, 1'b0, 2'b00, 3'd4, 8'h04, 16'h04F0, 1'b0, 1'b0, 4'd2},  // R2 not SP yellow addr
        {1'b0, 1'b1, 2'b00, 3'd1, 8'h04, 16'h0100, 1'b0, 1'b0, 4'd3},  // R3 read
        {1'b0, 1'b1, 2'b00, 3'd4, 8'h04, 16'h04F0, 1'b0, 1'b0, 4'd3},  // R3 read yellow addr
        {1'b1, 1'b1, 2'b00, 3'd4, 8'h04, 16'hFFFE, 1'b1, 1'b0, 4'd8},  // R8 PSW, low limit
        {1'b1, 1'b1, 2'b00, 3'd4, 8'h00, 16'hFFFE, 1'b1, 1'b0, 4'd8},  // R8 PSW, zero limit
        {1'b1, 1'b1, 2'b00, 3'd4, 8'hFF, 16'hFFFE, 1'b1, 1'b0, 4'd9},  // R9 PSW in yellow: red wins
        {1'b1, 1'b1, 2'b00, 3'd4, 8'hFF, 16'hFFFC, 1'b0, 1'b1, 4'd6},  // R6 top limit yellow
        {1'b1, 1'b1, 2'b00, 3'd4, 8'hFF, 16'hFFFF, 1'b0, 1'b1, 4'd6},  // R6 top limit last addr
        {1'b1, 1'b1, 2'b00, 3'd4, 8'hFF, 16'hFFDF, 1'b1, 1'b0, 4'd5},  // R5 top limit red
        {1'b1, 1'b1, 2'b00, 3'd1, 8'h00, 16'h00DF, 1'b1, 1'b0, 4'd5},  // R5 zero limit red
        {1'b1, 1'b1, 2'b00, 3'd1, 8'h00, 16'h00E0, 1'b0, 1'b1, 4'd6},  // R6 zero limit yellow
        {1'b1, 1'b1, 2'b00, 3'd1, 8'h00, 16'h0100, 1'b0, 1'b0, 4'd7}   // R7 zero limit legal
    };

    task automatic apply(input logic we, input logic sp, input logic [1:0] cm,
                         input logic [2:0] am, input logic [7:0] lim,
                         input logic [15:0] a);
        wr_strobe  = we;
        spec_is_sp = sp;
        cpu_mode   = cm;
        spec_mode  = am;
        stk_limit  = lim;
        wr_addr    = a;
    endtask

    task automatic check(input logic exp_red, input logic exp_yel,
                         input string req);
        checks++;
        if (zone_red !== exp_red || zone_yellow !== exp_yel) begin
            errors++;
            $display("FAIL %s addr=%h limit=%h: red/yel got %b%b exp %b%b",
                     req, wr_addr, stk_limit, zone_red, zone_yellow,
                     exp_red, exp_yel);
        end
        checks++;
        if (zone_red && zone_yellow) begin
            errors++;
            $display("FAIL R9 exclusive: red/yel got %b%b exp not 11",
                     zone_red, zone_yellow);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        apply(1'b0, 1'b0, 2'b00, 3'd0, 8'h00, 16'h0000);
        @(negedge clk);
        #1;
        check(1'b0, 1'b0, "R3 idle state");

        // Table walk: drive on the falling edge, sample 1 ns later.
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            apply(VEC[i][36], VEC[i][35], VEC[i][34:33], VEC[i][32:30],
                  VEC[i][29:22], VEC[i][21:6]);
            #1;
            check(VEC[i][5], VEC[i][4], $sformatf("R%0d vec%0d", VEC[i][3:0], i));
        end

        // R10: outputs change with no clock edge in between.
        @(negedge clk);
        apply(1'b1, 1'b1, 2'b00, 3'd4, 8'h10, 16'h10DF);
        #1;
        check(1'b1, 1'b0, "R10 step a");
        wr_addr = 16'h10E0;
        #1;
        check(1'b0, 1'b1, "R10 step b");
        wr_addr = 16'h1100;
        #1;
        check(1'b0, 1'b0, "R10 step c");

        // R5/R6 edges across every limit byte.
        for (int l = 0; l < 256; l++) begin
            @(negedge clk);
            apply(1'b1, 1'b1, 2'b00, 3'd6, 8'(l), 16'(l * 256 + 223));
            #1;
            check(1'b1, 1'b0, "R5 sweep");
            wr_addr = 16'(l * 256 + 224);
            #1;
            check(l == 255 && wr_addr == 16'hFFFE, l != 255 || wr_addr != 16'hFFFE,
                  "R6 sweep");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule